// File: doc/BRIEF.md
# Dual-Port Hardware Semaphore Bank

This block keeps eight binary tokens that two independent ports, called left and right, use to take turns on shared resources. The tokens live apart from any data storage. A port asks for a token by writing a 0 on data bit 0 and gives it back by writing a 1. Each side has its own request latch for every token. An arbiter for each token decides who owns it from the two latches and from the current owner.

A request that loses stays pending. When the owner lets go, the pending side takes the token without writing again. A read returns that port's view of the token (0 means "this side owns it", 1 means "this side does not") copied onto every data bit. The value is captured when the read access opens and stays fixed until it closes, so software that polls has to end the access and start a new one.

The ports are synchronous to one clock, and reset is synchronous and active high. A write is sampled on a rising edge and changes the port's latch on that edge. Ownership follows on the next edge. A read access that opens two or more edges after the write edge sees the result.

Top module: `semaphoreBank`

## Requirements
- R1: After reset every token is free: both read outputs are all ones before any access, and every token reads all ones from both sides.
- R2: The 3-bit index selects one of eight tokens, and each token behaves independently of the other seven.
- R3: A write (select and write strobe high on a clock edge) stores data bit 0 into that port's request latch for the indexed token. 0 means request and 1 means release, and data bits 17..1 have no effect.
- R4: A request for a free token gives it to the requester: that side reads 0 and the other side reads 1.
- R5: A request from the side that does not own the token leaves ownership unchanged. It stays pending, and when the owner releases, the token passes straight to the pending side.
- R6: A non-owner that writes 1 withdraws its pending request, so a later release by the owner leaves the token free.
- R7: A release by the owner with nothing pending makes the token free, and both sides read 1.
- R8: When both sides request a free token on the same edge, the left side wins. A request made on an earlier edge always wins over a later one from the other side.
- R9: A read drives the captured token view on all 18 data bits (all zeros or all ones).
- R10: The read value is captured on the first edge on which select and output enable are both high. It is held until one of them drops, and the next access captures again.
- R11: A write strobe without select has no effect, and a port's write never changes the other port's request latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| leftSel | input | 1 | Left semaphore select |
| leftWr | input | 1 | Left write strobe |
| leftRdEn | input | 1 | Left output enable |
| leftIdx | input | 3 | Left token index |
| leftWrData | input | 18 | Left write data (bit 0 used) |
| leftRdData | output | 18 | Left read data |
| rightSel | input | 1 | Right semaphore select |
| rightWr | input | 1 | Right write strobe |
| rightRdEn | input | 1 | Right output enable |
| rightIdx | input | 3 | Right token index |
| rightWrData | input | 18 | Right write data (bit 0 used) |
| rightRdData | output | 18 | Right read data |

## Verification
The hardest cases to reach from the ports depend on the relative timing of the two sides. One is a same-edge tie on a free token. Another is a request from the right made one edge before one from the left. A third is a pending request that has to take over when the owner releases. The bench drives both ports from a single task in fixed negedge slots to hit those edges. It also shows the read hold by keeping a read access open while the same port claims the token, then reopening the access to see the changed view.

// File: rtl/semPkg.sv
package semPkg;
  localparam int SEM_COUNT  = 8;
  localparam int SEM_IDX_W  = $clog2(SEM_COUNT);
  localparam int SEM_DATA_W = 18;
  localparam int NUM_PORTS  = 2;
  localparam int LEFT_P     = 0;
  localparam int RIGHT_P    = 1;

  typedef enum logic [1:0] {
    OWN_FREE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } owner_e;

  typedef struct packed {
    logic                 wrEn;
    logic [SEM_IDX_W-1:0] wrIdx;
    logic                 wrBit;
    logic                 capture;
    logic [SEM_IDX_W-1:0] rdIdx;
  } portStrobe_t;
endpackage

// File: rtl/semFlagArb.sv
module semFlagArb
  import semPkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   leftReq,
  input  logic   rightReq,
  output owner_e owner
);
  owner_e ownNext;

  always_comb begin
    ownNext = OWN_FREE;
    unique case (owner)
      OWN_LEFT: begin
        if (leftReq)       ownNext = OWN_LEFT;
        else if (rightReq) ownNext = OWN_RIGHT;
      end
      OWN_RIGHT: begin
        if (rightReq)      ownNext = OWN_RIGHT;
        else if (leftReq)  ownNext = OWN_LEFT;
      end
      default: begin
        if (leftReq)       ownNext = OWN_LEFT;
        else if (rightReq) ownNext = OWN_RIGHT;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) owner <= OWN_FREE;
    else     owner <= ownNext;
  end

  // R8: a same-edge tie on a free token goes to the left side
  assert_tie_left_R8: assert property (@(posedge clk) disable iff (rst)
    (owner == OWN_FREE && leftReq && rightReq) |=> owner == OWN_LEFT);

  // R5: an owner that still holds its request keeps the token
  assert_left_keeps_R5: assert property (@(posedge clk) disable iff (rst)
    (owner == OWN_LEFT && leftReq) |=> owner == OWN_LEFT);
  assert_right_keeps_R5: assert property (@(posedge clk) disable iff (rst)
    (owner == OWN_RIGHT && rightReq) |=> owner == OWN_RIGHT);

  // R5: a release passes the token to the pending side
  assert_handoff_R5: assert property (@(posedge clk) disable iff (rst)
    (owner == OWN_LEFT && !leftReq && rightReq) |=> owner == OWN_RIGHT);

  // R7: with no request held the token becomes free
  assert_goes_free_R7: assert property (@(posedge clk) disable iff (rst)
    (!leftReq && !rightReq) |=> owner == OWN_FREE);
endmodule

// File: rtl/semCtrl.sv
module semCtrl
  import semPkg::*;
#(
  parameter int DATA_W = SEM_DATA_W
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic [NUM_PORTS-1:0]                  sel,
  input  logic [NUM_PORTS-1:0]                  wrStb,
  input  logic [NUM_PORTS-1:0]                  rdEn,
  input  logic [NUM_PORTS-1:0][SEM_IDX_W-1:0]   idx,
  input  logic [NUM_PORTS-1:0][DATA_W-1:0]      wrData,
  output portStrobe_t [NUM_PORTS-1:0]           strb
);
  logic [NUM_PORTS-1:0] accNow;
  logic [NUM_PORTS-1:0] accQ;
  logic                 unusedHighBits;

  assign accNow = sel & rdEn;

  always_ff @(posedge clk) begin
    if (rst) accQ <= '0;
    else     accQ <= accNow;
  end

  always_comb begin
    unusedHighBits = 1'b0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      strb[p].wrEn    = sel[p] & wrStb[p];
      strb[p].wrIdx   = idx[p];
      strb[p].wrBit   = wrData[p][0];
      strb[p].capture = accNow[p] & ~accQ[p];
      strb[p].rdIdx   = idx[p];
      unusedHighBits  = unusedHighBits ^ (^wrData[p][DATA_W-1:1]);
    end
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : gChk
    // R10: capture fires once per access, never on two edges in a row
    assert_capture_once_R10: assert property (@(posedge clk) disable iff (rst)
      strb[p].capture |=> !strb[p].capture);
    // R11: no write strobe reaches the datapath without select
    assert_no_write_unselected_R11: assert property (@(posedge clk) disable iff (rst)
      !sel[p] |-> !strb[p].wrEn);
  end
endmodule

// File: rtl/semDatapath.sv
module semDatapath
  import semPkg::*;
#(
  parameter int DATA_W = SEM_DATA_W
) (
  input  logic                              clk,
  input  logic                              rst,
  input  portStrobe_t [NUM_PORTS-1:0]       strb,
  output logic [NUM_PORTS-1:0][DATA_W-1:0]  rdData
);
  // request latches, 1 = idle, 0 = requesting
  logic [NUM_PORTS-1:0][SEM_COUNT-1:0] reqN;
  logic [NUM_PORTS-1:0][SEM_COUNT-1:0] view;
  logic [NUM_PORTS-1:0]                rdHold;
  owner_e                              ownQ [SEM_COUNT];

  always_ff @(posedge clk) begin
    if (rst) begin
      reqN <= '1;
    end else begin
      for (int p = 0; p < NUM_PORTS; p++) begin
        if (strb[p].wrEn) reqN[p][strb[p].wrIdx] <= strb[p].wrBit;
      end
    end
  end

  for (genvar i = 0; i < SEM_COUNT; i++) begin : gFlag
    semFlagArb uArb (
      .clk      (clk),
      .rst      (rst),
      .leftReq  (~reqN[LEFT_P][i]),
      .rightReq (~reqN[RIGHT_P][i]),
      .owner    (ownQ[i])
    );
  end

  always_comb begin
    for (int i = 0; i < SEM_COUNT; i++) begin
      view[LEFT_P][i]  = (ownQ[i] != OWN_LEFT);
      view[RIGHT_P][i] = (ownQ[i] != OWN_RIGHT);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdHold <= '1;
    end else begin
      for (int p = 0; p < NUM_PORTS; p++) begin
        if (strb[p].capture) rdHold[p] <= view[p][strb[p].rdIdx];
      end
    end
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : gOut
    assign rdData[p] = {DATA_W{rdHold[p]}};

    // R10: the read value only moves on a capture edge
    assert_read_frozen_R10: assert property (@(posedge clk) disable iff (rst)
      !strb[p].capture |=> $stable(rdHold[p]));
    // R11: a port's latches change only when that port writes
    assert_own_latch_only_R11: assert property (@(posedge clk) disable iff (rst)
      !strb[p].wrEn |=> $stable(reqN[p]));
  end
endmodule

// File: rtl/semaphoreBank.sv
module semaphoreBank
  import semPkg::*;
#(
  parameter int DATA_W = SEM_DATA_W,
  parameter int IDX_W  = SEM_IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              leftSel,
  input  logic              leftWr,
  input  logic              leftRdEn,
  input  logic [IDX_W-1:0]  leftIdx,
  input  logic [DATA_W-1:0] leftWrData,
  output logic [DATA_W-1:0] leftRdData,
  input  logic              rightSel,
  input  logic              rightWr,
  input  logic              rightRdEn,
  input  logic [IDX_W-1:0]  rightIdx,
  input  logic [DATA_W-1:0] rightWrData,
  output logic [DATA_W-1:0] rightRdData
);
  portStrobe_t [NUM_PORTS-1:0]          strb;
  logic [NUM_PORTS-1:0][DATA_W-1:0]     rdBus;

  semCtrl #(.DATA_W(DATA_W)) uCtrl (
    .clk    (clk),
    .rst    (rst),
    .sel    ({rightSel, leftSel}),
    .wrStb  ({rightWr, leftWr}),
    .rdEn   ({rightRdEn, leftRdEn}),
    .idx    ({rightIdx, leftIdx}),
    .wrData ({rightWrData, leftWrData}),
    .strb   (strb)
  );

  semDatapath #(.DATA_W(DATA_W)) uData (
    .clk    (clk),
    .rst    (rst),
    .strb   (strb),
    .rdData (rdBus)
  );

  assign leftRdData  = rdBus[LEFT_P];
  assign rightRdData = rdBus[RIGHT_P];
endmodule

// File: tb/semaphoreBank_test.sv
module semaphoreBank_test;
  localparam logic [17:0] ONES  = 18'h3FFFF;
  localparam logic [17:0] ZEROS = 18'h00000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] sel = '0, wr = '0, rd = '0;
  logic [1:0][2:0]  idx = '0;
  logic [1:0][17:0] wd  = '0;
  logic [17:0] lRd, rRd;
  int nChk = 0, nBad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  semaphoreBank uut (
    .clk(clk), .rst(rst),
    .leftSel(sel[0]), .leftWr(wr[0]), .leftRdEn(rd[0]), .leftIdx(idx[0]),
    .leftWrData(wd[0]), .leftRdData(lRd),
    .rightSel(sel[1]), .rightWr(wr[1]), .rightRdEn(rd[1]), .rightIdx(idx[1]),
    .rightWrData(wd[1]), .rightRdData(rRd)
  );

  task automatic chk(string req, logic [17:0] act, logic [17:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [17:0] rdOf(int s);
    return (s == 0) ? lRd : rRd;
  endfunction

  task automatic wrSem(int s, int i, logic [17:0] d);
    @(negedge clk);
    sel[s] = 1'b1; wr[s] = 1'b1; idx[s] = 3'(i); wd[s] = d;
    @(negedge clk);
    sel[s] = 1'b0; wr[s] = 1'b0; wd[s] = '0;
    @(negedge clk);
  endtask

  task automatic rdSem(int s, int i, output logic [17:0] v);
    @(negedge clk);
    sel[s] = 1'b1; rd[s] = 1'b1; idx[s] = 3'(i);
    @(negedge clk);
    v = rdOf(s);
    sel[s] = 1'b0; rd[s] = 1'b0;
  endtask

  task automatic expView(string req, int i, logic [17:0] eL, logic [17:0] eR);
    logic [17:0] v;
    rdSem(0, i, v); chk({req, " left"}, v, eL);
    rdSem(1, i, v); chk({req, " right"}, v, eR);
  endtask

  task automatic tReset();
    chk("R1 left out after reset", lRd, ONES);
    chk("R1 right out after reset", rRd, ONES);
    for (int i = 0; i < 8; i++) expView("R1 token free", i, ONES, ONES);
  endtask

  task automatic tClaim();
    wrSem(0, 2, 18'h3FFFE);                     // bit0=0, other bits 1
    expView("R4 R3 R9 left claims 2", 2, ZEROS, ONES);
    expView("R2 token 3 untouched", 3, ONES, ONES);
  endtask

  task automatic tPending();
    wrSem(1, 2, ZEROS);
    expView("R5 owner kept", 2, ZEROS, ONES);
    wrSem(0, 2, 18'h00001);                     // release, upper bits 0
    expView("R5 R3 handoff to right", 2, ONES, ZEROS);
  endtask

  task automatic tWithdraw();
    wrSem(0, 2, ZEROS);
    wrSem(0, 2, ONES);
    wrSem(1, 2, ONES);
    expView("R6 R7 withdrawn then free", 2, ONES, ONES);
  endtask

  task automatic tTie();
    @(negedge clk);
    sel = 2'b11; wr = 2'b11; idx[0] = 3'd4; idx[1] = 3'd4; wd[0] = '0; wd[1] = '0;
    @(negedge clk);
    sel = '0; wr = '0;
    @(negedge clk);
    expView("R8 tie to left", 4, ZEROS, ONES);
    wrSem(0, 4, ONES);
    expView("R5 tie loser takes over", 4, ONES, ZEROS);
    wrSem(1, 4, ONES);
    expView("R7 tie token free", 4, ONES, ONES);
  endtask

  task automatic tEarlier();
    @(negedge clk);
    sel[1] = 1'b1; wr[1] = 1'b1; idx[1] = 3'd5; wd[1] = '0;
    @(negedge clk);
    sel[1] = 1'b0; wr[1] = 1'b0;
    sel[0] = 1'b1; wr[0] = 1'b1; idx[0] = 3'd5; wd[0] = '0;
    @(negedge clk);
    sel[0] = 1'b0; wr[0] = 1'b0;
    @(negedge clk);
    expView("R8 earlier right wins", 5, ONES, ZEROS);
    wrSem(1, 5, ONES);
    expView("R5 left pending takes", 5, ZEROS, ONES);
    wrSem(0, 5, ONES);
    expView("R7 token 5 free", 5, ONES, ONES);
  endtask

  task automatic tIndex();
    wrSem(1, 7, ZEROS);
    expView("R2 token 7 owned right", 7, ONES, ZEROS);
    expView("R2 token 6 free", 6, ONES, ONES);
    expView("R2 token 0 free", 0, ONES, ONES);
    wrSem(1, 7, ONES);
    expView("R7 token 7 free", 7, ONES, ONES);
  endtask

  task automatic tNoSel();
    @(negedge clk);
    wr[0] = 1'b1; idx[0] = 3'd1; wd[0] = '0;    // strobe without select
    @(negedge clk);
    wr[0] = 1'b0;
    @(negedge clk);
    expView("R11 unselected write ignored", 1, ONES, ONES);
  endtask

  task automatic tFrozen();
    @(negedge clk);
    sel[0] = 1'b1; rd[0] = 1'b1; idx[0] = 3'd0;
    @(negedge clk);
    chk("R10 first capture", lRd, ONES);
    wr[0] = 1'b1; wd[0] = '0;
    @(negedge clk);
    wr[0] = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R10 value held during access", lRd, ONES);
    rd[0] = 1'b0;
    @(negedge clk);
    rd[0] = 1'b1;
    @(negedge clk);
    chk("R10 new access recaptures", lRd, ZEROS);
    sel[0] = 1'b0; rd[0] = 1'b0;
    wrSem(0, 0, ONES);
    expView("R7 token 0 free again", 0, ONES, ONES);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    tReset();
    tClaim();
    tPending();
    tWithdraw();
    tTie();
    tEarlier();
    tIndex();
    tNoSel();
    tFrozen();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChk++;
      nBad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end
endmodule